// File: doc/BRIEF.md
# Queue Doorbell Write Decoder

This block sits behind the register slave port of a host-attached storage controller and turns host writes into the doorbell window into pointer updates. Each queue owns two 32-bit doorbell slots. The submission-queue tail slot and the completion-queue head slot of a queue sit next to each other, so the per-queue stride is 8 bytes. A write is accepted only when the queue it names exists and the new pointer is inside that queue's ring. An accepted submission tail becomes a tail-load strobe and arms a per-queue fetch countdown. An accepted completion head becomes a head-load strobe for the completion ring.

A completion head write can free a ring that was full. When it does, the block re-arms the fetch countdown of every live submission queue bound to that ring and also arms a countdown that restarts the completion poster. When the ring still holds entries after the head moves, and interrupts are on for that ring, the block requests the interrupt again. The queue tables (existence, depth, binding, current ring pointers, interrupt enable) are held elsewhere and arrive as flat vectors. The fetch engine, the poster and interrupt delivery consume the strobes and pulses this block produces.

Top module: `dbell_decoder`

## Requirements
- R1: A write whose address is below the window base (0x1000) produces no strobe, no countdown and no interrupt request.
- R2: A write whose address has either of bits [1:0] set produces no strobe, no countdown and no interrupt request.
- R3: With offset = address - 0x1000, an accepted write with offset bit 2 clear raises `sq_tail_we` for one cycle, on the cycle after the write, with `sq_tail_qid` = offset >> 3.
- R4: An accepted write with offset bit 2 set raises `cq_head_we` for one cycle, on the cycle after the write, with `cq_head_qid` = (address - 0x1004) >> 3.
- R5: The pointer value carried on `sq_tail_val` or `cq_head_val` is bits [15:0] of the write data; bits [31:16] are ignored.
- R6: A write naming a queue index not below NUM_Q, or a queue whose live bit is 0, is dropped with no output.
- R7: A write whose pointer value is greater than or equal to the depth of the named queue is dropped with no output.
- R8: An accepted submission tail write to queue q makes `sq_fetch[q]` high for exactly one cycle, DELAY_CYC cycles after the write cycle.
- R9: A new arming of a queue's countdown restarts it from DELAY_CYC. A pending fetch is replaced and not duplicated, and this holds when the new arming lands in the very cycle the old countdown would have fired.
- R10: When a completion head write is accepted and the ring was full before it ((tail + 1) mod depth == head), every live submission queue bound to that ring is armed as in R8, and `cq_post[q]` pulses once DELAY_CYC cycles after the write. A ring that was not full arms nothing.
- R11: An accepted completion head write raises `irq_req` with `irq_qid` = that queue, on the same cycle as `cq_head_we`, if and only if the ring's interrupt enable is 1 and its tail differs from the new head.
- R12: While reset is asserted, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write valid |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 32 | Write data |
| sq_live | input | NUM_Q | Submission queue q exists |
| cq_live | input | NUM_Q | Completion queue q exists |
| sq_depth | input | NUM_Q*16 | Entry count of each submission ring |
| cq_depth | input | NUM_Q*16 | Entry count of each completion ring |
| sq_cq_map | input | NUM_Q*6 | Completion queue each submission queue posts to |
| cq_tail_ptr | input | NUM_Q*16 | Current producer index of each completion ring |
| cq_head_ptr | input | NUM_Q*16 | Current consumer index of each completion ring |
| cq_irq_on | input | NUM_Q | Interrupts enabled per completion ring |
| sq_tail_we | output | 1 | Load new submission tail |
| sq_tail_qid | output | 6 | Queue for the tail load |
| sq_tail_val | output | 16 | New tail value |
| cq_head_we | output | 1 | Load new completion head |
| cq_head_qid | output | 6 | Queue for the head load |
| cq_head_val | output | 16 | New head value |
| sq_fetch | output | NUM_Q | Per-queue fetch request pulse |
| cq_post | output | NUM_Q | Per-ring poster restart pulse |
| irq_req | output | 1 | Interrupt request pulse |
| irq_qid | output | 6 | Ring the interrupt belongs to |

## Verification
Two events can meet on one queue in one cycle: a countdown reaches its end while a fresh doorbell, or a restart from a freed completion ring, re-arms that same queue. The bench provokes this directly. It issues a second tail write exactly DELAY_CYC cycles after the first, and it also issues a freeing head write while a bound queue's countdown is still pending. A per-queue deadline model then judges the result: the fetch pulse must appear only at the latest deadline, and the pulse count per queue must match. Random writes with random tables exercise the same model over many mixes of the two doorbell kinds.

// File: rtl/dbell_pkg.sv
package dbell_pkg;

  localparam int QID_W = 6;
  localparam int PTR_W = 16;

  typedef struct packed {
    logic             hit;
    logic             is_cq;
    logic [QID_W-1:0] qid;
    logic [PTR_W-1:0] ptr;
  } db_req_t;

  // Byte offset of a write inside the doorbell window.
  function automatic logic [31:0] win_offset(input logic [31:0] addr,
                                             input logic [31:0] base);
    return addr - base;
  endfunction

  // Queue slot number: two 4-byte doorbells per queue.
  function automatic logic [31:0] slot_of(input logic [31:0] off);
    return off >> 3;
  endfunction

  // Ring is full when advancing the producer would meet the consumer.
  function automatic logic ring_full(input logic [PTR_W-1:0] tail,
                                     input logic [PTR_W-1:0] head,
                                     input logic [PTR_W-1:0] depth);
    logic [PTR_W-1:0] nx;
    nx = tail + PTR_W'(1);
    if (nx == depth) nx = '0;
    return nx == head;
  endfunction

endpackage

// File: rtl/dbell_decode.sv
module dbell_decode
  import dbell_pkg::*;
#(
  parameter int                ADDR_W = 16,
  parameter int                NUM_Q  = 8,
  parameter logic [ADDR_W-1:0] BASE   = ADDR_W'('h1000),
  localparam int               IW     = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [NUM_Q-1:0]  sq_live,
  input  logic [NUM_Q-1:0]  cq_live,
  input  logic [PTR_W-1:0]  sq_depth [NUM_Q],
  input  logic [PTR_W-1:0]  cq_depth [NUM_Q],
  output db_req_t           req,
  output logic [IW-1:0]     req_idx
);

  logic [31:0]      off;
  logic [31:0]      slot;
  logic             in_win;
  logic             aligned;
  logic             in_range;
  logic             live;
  logic [PTR_W-1:0] limit;
  logic [PTR_W-1:0] ptr;
  logic             unused_bits;

  assign off      = win_offset(32'(wr_addr), 32'(BASE));
  assign slot     = slot_of(off);
  assign in_win   = (wr_addr >= BASE);
  assign aligned  = (wr_addr[1:0] == 2'b00);
  assign in_range = (slot < 32'(NUM_Q));
  assign req_idx  = in_range ? slot[IW-1:0] : '0;
  assign ptr      = wr_data[PTR_W-1:0];
  assign unused_bits = ^{wr_data[31:PTR_W], off[1:0]};

  assign live  = off[2] ? cq_live[req_idx]  : sq_live[req_idx];
  assign limit = off[2] ? cq_depth[req_idx] : sq_depth[req_idx];

  always_comb begin
    req.hit   = wr_en & in_win & aligned & in_range & live & (ptr < limit);
    req.is_cq = off[2];
    req.qid   = slot[QID_W-1:0];
    req.ptr   = ptr;
  end

endmodule

// File: rtl/dbell_restart.sv
module dbell_restart
  import dbell_pkg::*;
#(
  parameter int NUM_Q = 8
) (
  input  logic             go,
  input  logic [QID_W-1:0] cq_qid,
  input  logic [NUM_Q-1:0] sq_live,
  input  logic [QID_W-1:0] sq_map [NUM_Q],
  output logic [NUM_Q-1:0] sq_mask,
  output logic [NUM_Q-1:0] cq_kick
);

  for (genvar s = 0; s < NUM_Q; s++) begin : g_sq
    assign sq_mask[s] = go & sq_live[s] & (sq_map[s] == cq_qid);
  end

  for (genvar c = 0; c < NUM_Q; c++) begin : g_cq
    assign cq_kick[c] = go & (cq_qid == QID_W'(c));
  end

endmodule

// File: rtl/dbell_delay_bank.sv
module dbell_delay_bank #(
  parameter int N     = 8,
  parameter int DELAY = 50,
  localparam int CW   = $clog2(DELAY + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] reload,
  output logic [N-1:0] fire
);

  for (genvar i = 0; i < N; i++) begin : g_lane
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt     <= '0;
        fire[i] <= 1'b0;
      end else begin
        fire[i] <= !reload[i] && (cnt == CW'(1));
        if (reload[i])       cnt <= CW'(DELAY);
        else if (cnt != '0)  cnt <= cnt - CW'(1);
      end
    end

    // R9: a lane armed this cycle cannot fire on the next one
    a_r9_reload_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      reload[i] |=> !fire[i]);

    if (DELAY > 1) begin : g_one
      // R8: each fetch request lasts a single cycle
      a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        fire[i] |=> !fire[i]);
    end
  end

endmodule

// File: rtl/dbell_decoder.sv
module dbell_decoder
  import dbell_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter int                NUM_Q     = 8,
  parameter int                DELAY_CYC = 50,
  parameter logic [ADDR_W-1:0] BASE      = ADDR_W'('h1000)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [31:0]             wr_data,
  input  logic [NUM_Q-1:0]        sq_live,
  input  logic [NUM_Q-1:0]        cq_live,
  input  logic [NUM_Q*PTR_W-1:0]  sq_depth,
  input  logic [NUM_Q*PTR_W-1:0]  cq_depth,
  input  logic [NUM_Q*QID_W-1:0]  sq_cq_map,
  input  logic [NUM_Q*PTR_W-1:0]  cq_tail_ptr,
  input  logic [NUM_Q*PTR_W-1:0]  cq_head_ptr,
  input  logic [NUM_Q-1:0]        cq_irq_on,
  output logic                    sq_tail_we,
  output logic [QID_W-1:0]        sq_tail_qid,
  output logic [PTR_W-1:0]        sq_tail_val,
  output logic                    cq_head_we,
  output logic [QID_W-1:0]        cq_head_qid,
  output logic [PTR_W-1:0]        cq_head_val,
  output logic [NUM_Q-1:0]        sq_fetch,
  output logic [NUM_Q-1:0]        cq_post,
  output logic                    irq_req,
  output logic [QID_W-1:0]        irq_qid
);

  localparam int IW = (NUM_Q > 1) ? $clog2(NUM_Q) : 1;

  // Unpacked views of the flat queue tables.
  logic [PTR_W-1:0] sq_depth_a [NUM_Q];
  logic [PTR_W-1:0] cq_depth_a [NUM_Q];
  logic [PTR_W-1:0] cq_tail_a  [NUM_Q];
  logic [PTR_W-1:0] cq_head_a  [NUM_Q];
  logic [QID_W-1:0] sq_map_a   [NUM_Q];

  for (genvar g = 0; g < NUM_Q; g++) begin : g_unpack
    assign sq_depth_a[g] = sq_depth[g*PTR_W +: PTR_W];
    assign cq_depth_a[g] = cq_depth[g*PTR_W +: PTR_W];
    assign cq_tail_a[g]  = cq_tail_ptr[g*PTR_W +: PTR_W];
    assign cq_head_a[g]  = cq_head_ptr[g*PTR_W +: PTR_W];
    assign sq_map_a[g]   = sq_cq_map[g*QID_W +: QID_W];
  end

  db_req_t       req;
  logic [IW-1:0] idx;

  dbell_decode #(
    .ADDR_W (ADDR_W),
    .NUM_Q  (NUM_Q),
    .BASE   (BASE)
  ) u_decode (
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .sq_live  (sq_live),
    .cq_live  (cq_live),
    .sq_depth (sq_depth_a),
    .cq_depth (cq_depth_a),
    .req      (req),
    .req_idx  (idx)
  );

  // Named internal events.
  logic sq_db_ok;
  logic cq_db_ok;
  logic ring_was_full;
  logic restart_go;
  logic irq_again;

  assign sq_db_ok      = req.hit & ~req.is_cq;
  assign cq_db_ok      = req.hit &  req.is_cq;
  assign ring_was_full = ring_full(cq_tail_a[idx], cq_head_a[idx], cq_depth_a[idx]);
  assign restart_go    = cq_db_ok & ring_was_full;
  assign irq_again     = cq_db_ok & cq_irq_on[idx] & (cq_tail_a[idx] != req.ptr);

  logic [NUM_Q-1:0] sq_hit_oh;
  logic [NUM_Q-1:0] sq_restart;
  logic [NUM_Q-1:0] cq_kick;
  logic [NUM_Q-1:0] sq_reload;

  for (genvar q = 0; q < NUM_Q; q++) begin : g_sq_oh
    assign sq_hit_oh[q] = sq_db_ok & (idx == IW'(q));
  end

  dbell_restart #(
    .NUM_Q (NUM_Q)
  ) u_restart (
    .go      (restart_go),
    .cq_qid  (req.qid),
    .sq_live (sq_live),
    .sq_map  (sq_map_a),
    .sq_mask (sq_restart),
    .cq_kick (cq_kick)
  );

  assign sq_reload = sq_hit_oh | sq_restart;

  dbell_delay_bank #(
    .N     (NUM_Q),
    .DELAY (DELAY_CYC)
  ) u_sq_delay (
    .clk    (clk),
    .rst_n  (rst_n),
    .reload (sq_reload),
    .fire   (sq_fetch)
  );

  dbell_delay_bank #(
    .N     (NUM_Q),
    .DELAY (DELAY_CYC)
  ) u_cq_delay (
    .clk    (clk),
    .rst_n  (rst_n),
    .reload (cq_kick),
    .fire   (cq_post)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sq_tail_we  <= 1'b0;
      sq_tail_qid <= '0;
      sq_tail_val <= '0;
      cq_head_we  <= 1'b0;
      cq_head_qid <= '0;
      cq_head_val <= '0;
      irq_req     <= 1'b0;
      irq_qid     <= '0;
    end else begin
      sq_tail_we <= sq_db_ok;
      cq_head_we <= cq_db_ok;
      irq_req    <= irq_again;
      if (sq_db_ok) begin
        sq_tail_qid <= req.qid;
        sq_tail_val <= req.ptr;
      end
      if (cq_db_ok) begin
        cq_head_qid <= req.qid;
        cq_head_val <= req.ptr;
      end
      if (irq_again) irq_qid <= req.qid;
    end
  end

  // R3/R4: one write yields at most one kind of pointer load
  a_r3_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
    !(sq_tail_we && cq_head_we));

  // R1: every load comes from an address inside the window
  a_r1_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_tail_we || cq_head_we) |-> ($past(wr_addr) >= BASE));

  // R2: every load comes from a word-aligned address
  a_r2_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_tail_we || cq_head_we) |-> ($past(wr_addr[1:0]) == 2'b00));

  // R11: interrupt request travels with the head load of the same ring
  a_r11_irq_with_head: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (cq_head_we && (irq_qid == cq_head_qid)));

  // R6: a tail load names a queue that was live when written
  a_r6_live_sq: assert property (@(posedge clk) disable iff (!rst_n)
    sq_tail_we |-> ((($past(sq_live) >> sq_tail_qid) & NUM_Q'(1)) != '0));

endmodule

// File: tb/sim_dbell_decoder.sv
`timescale 1ns/1ps
module sim_dbell_decoder;

  localparam int NQ = 8;
  localparam int D  = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic             wr_en = 1'b0;
  logic [15:0]      wr_addr = '0;
  logic [31:0]      wr_data = '0;
  logic [NQ-1:0]    sq_live, cq_live, cq_irq_on;
  logic [NQ*16-1:0] sq_depth, cq_depth, cq_tail_ptr, cq_head_ptr;
  logic [NQ*6-1:0]  sq_cq_map;
  logic             sq_tail_we, cq_head_we, irq_req;
  logic [5:0]       sq_tail_qid, cq_head_qid, irq_qid;
  logic [15:0]      sq_tail_val, cq_head_val;
  logic [NQ-1:0]    sq_fetch, cq_post;

  // bench-side queue tables
  bit       b_sq_live [NQ];
  bit       b_cq_live [NQ];
  bit       b_irq     [NQ];
  int       b_sq_dep  [NQ];
  int       b_cq_dep  [NQ];
  int       b_tail    [NQ];
  int       b_head    [NQ];
  int       b_map     [NQ];

  always_comb begin
    for (int i = 0; i < NQ; i++) begin
      sq_live[i]              = b_sq_live[i];
      cq_live[i]              = b_cq_live[i];
      cq_irq_on[i]            = b_irq[i];
      sq_depth[i*16 +: 16]    = b_sq_dep[i][15:0];
      cq_depth[i*16 +: 16]    = b_cq_dep[i][15:0];
      cq_tail_ptr[i*16 +: 16] = b_tail[i][15:0];
      cq_head_ptr[i*16 +: 16] = b_head[i][15:0];
      sq_cq_map[i*6 +: 6]     = b_map[i][5:0];
    end
  end

  dbell_decoder #(.NUM_Q(NQ), .DELAY_CYC(D)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sq_live(sq_live), .cq_live(cq_live), .sq_depth(sq_depth), .cq_depth(cq_depth),
    .sq_cq_map(sq_cq_map), .cq_tail_ptr(cq_tail_ptr), .cq_head_ptr(cq_head_ptr),
    .cq_irq_on(cq_irq_on), .sq_tail_we(sq_tail_we), .sq_tail_qid(sq_tail_qid),
    .sq_tail_val(sq_tail_val), .cq_head_we(cq_head_we), .cq_head_qid(cq_head_qid),
    .cq_head_val(cq_head_val), .sq_fetch(sq_fetch), .cq_post(cq_post),
    .irq_req(irq_req), .irq_qid(irq_qid));

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Expected decision for one write, from the requirements
  bit       m_sq, m_cq, m_irq, m_kick;
  int       m_q, m_val;
  bit [NQ-1:0] m_restart;

  task automatic model(input int addr, input int data);
    int rel, q, v;
    m_sq = 0; m_cq = 0; m_irq = 0; m_kick = 0; m_q = 0; m_val = 0; m_restart = '0;
    if (addr < 4096) return;
    if (addr % 4 != 0) return;
    rel = addr - 4096;
    q   = rel / 8;
    if (q >= NQ) return;
    v   = data & 32'hFFFF;
    if (rel % 8 == 4) begin
      if (!b_cq_live[q] || v >= b_cq_dep[q]) return;
      m_cq = 1; m_q = q; m_val = v;
      m_irq = b_irq[q] && (b_tail[q] != v);
      if (((b_tail[q] + 1) % b_cq_dep[q]) == b_head[q]) begin
        m_kick = 1;
        for (int s = 0; s < NQ; s++) m_restart[s] = b_sq_live[s] && (b_map[s] == q);
      end
    end else begin
      if (!b_sq_live[q] || v >= b_sq_dep[q]) return;
      m_sq = 1; m_q = q; m_val = v;
    end
  endtask

  // Lockstep scoreboard: deadlines in edge numbers
  longint cyc = 0;
  longint dl  [NQ];
  longint pdl [NQ];
  bit     e_sq, e_cq, e_irq;
  int     e_q, e_val;
  int     fcnt [NQ];
  int     pcnt [NQ];
  bit     sb_on = 0;

  initial for (int i = 0; i < NQ; i++) begin
    dl[i] = -1; pdl[i] = -1; fcnt[i] = 0; pcnt[i] = 0;
  end

  always @(posedge clk) begin
    if (rst_n) begin
      cyc   <= cyc + 1;
      e_sq  <= m_sq;
      e_cq  <= m_cq;
      e_irq <= m_irq;
      e_q   <= m_q;
      e_val <= m_val;
      for (int s = 0; s < NQ; s++) begin
        if ((m_sq && m_q == s) || m_restart[s]) dl[s] <= cyc + 1 + D;
        if (m_kick && m_q == s) pdl[s] <= cyc + 1 + D;
      end
    end
  end

  always @(negedge clk) begin
    if (sb_on) begin
      chk(sq_tail_we == e_sq, "R3", "sq_tail_we", sq_tail_we, e_sq);
      if (e_sq) begin
        chk(sq_tail_qid == 6'(e_q), "R3", "sq_tail_qid", sq_tail_qid, e_q);
        chk(sq_tail_val == 16'(e_val), "R5", "sq_tail_val", sq_tail_val, e_val);
      end
      chk(cq_head_we == e_cq, "R4", "cq_head_we", cq_head_we, e_cq);
      if (e_cq) begin
        chk(cq_head_qid == 6'(e_q), "R4", "cq_head_qid", cq_head_qid, e_q);
        chk(cq_head_val == 16'(e_val), "R5", "cq_head_val", cq_head_val, e_val);
      end
      chk(irq_req == e_irq, "R11", "irq_req", irq_req, e_irq);
      if (e_irq) chk(irq_qid == 6'(e_q), "R11", "irq_qid", irq_qid, e_q);
      for (int s = 0; s < NQ; s++) begin
        chk(sq_fetch[s] == (dl[s] == cyc), "R8", $sformatf("sq_fetch[%0d]", s),
            sq_fetch[s], dl[s] == cyc);
        chk(cq_post[s] == (pdl[s] == cyc), "R10", $sformatf("cq_post[%0d]", s),
            cq_post[s], pdl[s] == cyc);
        fcnt[s] += int'(sq_fetch[s]);
        pcnt[s] += int'(cq_post[s]);
      end
    end
  end

  // Captured outputs after each write
  bit o_sq, o_cq, o_irq;

  task automatic wr(input int addr, input int data);
    @(posedge clk); #2;
    wr_en = 1'b1; wr_addr = addr[15:0]; wr_data = data;
    model(addr, data);
    @(posedge clk); #2;
    wr_en = 1'b0;
    m_sq = 0; m_cq = 0; m_irq = 0; m_kick = 0; m_restart = '0;
    @(negedge clk);
    o_sq = sq_tail_we; o_cq = cq_head_we; o_irq = irq_req;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic tables_default();
    for (int i = 0; i < NQ; i++) begin
      b_sq_live[i] = 1; b_cq_live[i] = 1; b_irq[i] = 1;
      b_sq_dep[i] = 16; b_cq_dep[i] = 16;
      b_tail[i] = 5; b_head[i] = 0; b_map[i] = i % 4;
    end
  endtask

  task automatic tables_random();
    for (int i = 0; i < NQ; i++) begin
      b_sq_live[i] = ($urandom % 5) != 0;
      b_cq_live[i] = ($urandom % 5) != 0;
      b_irq[i]     = $urandom % 2;
      b_sq_dep[i]  = 2 + $urandom % 15;
      b_cq_dep[i]  = 2 + $urandom % 15;
      b_tail[i]    = $urandom % b_cq_dep[i];
      b_head[i]    = ($urandom % 3 == 0) ? (b_tail[i] + 1) % b_cq_dep[i]
                                         : $urandom % b_cq_dep[i];
      b_map[i]     = $urandom % NQ;
    end
  endtask

  function automatic int sq_db(input int q); return 32'h1000 + 8 * q; endfunction
  function automatic int cq_db(input int q); return 32'h1000 + 8 * q + 4; endfunction

  initial begin
    int f2, f6, p2, f1, f5, p1;
    void'($urandom(32'h5EED_0042));
    tables_default();
    repeat (3) @(negedge clk);
    chk({sq_tail_we, cq_head_we, irq_req, sq_fetch, cq_post} == '0, "R12",
        "outputs in reset", {sq_tail_we, cq_head_we, irq_req, sq_fetch, cq_post}, 0);
    chk({sq_tail_qid, sq_tail_val, cq_head_qid, cq_head_val, irq_qid} == '0, "R12",
        "fields in reset", {sq_tail_qid, sq_tail_val, cq_head_qid, cq_head_val, irq_qid}, 0);
    @(posedge clk); #2; rst_n = 1'b1;
    sb_on = 1;

    // R1: below the window
    wr(32'h0FF8, 3);
    chk(!o_sq && !o_cq && !o_irq, "R1", "write below window", {o_sq, o_cq, o_irq}, 0);
    // R2: unaligned
    wr(sq_db(2) + 1, 3);
    chk(!o_sq && !o_cq, "R2", "unaligned write", {o_sq, o_cq}, 0);
    wr(cq_db(3) + 2, 3);
    chk(!o_sq && !o_cq, "R2", "unaligned head write", {o_sq, o_cq}, 0);
    // R3: tail doorbell
    wr(sq_db(2), 5);
    chk(o_sq && sq_tail_qid == 2 && sq_tail_val == 5, "R3", "tail load q2",
        {o_sq, sq_tail_qid, sq_tail_val}, {1'b1, 6'd2, 16'd5});
    // R4 + R11: head doorbell with tail != head
    wr(cq_db(3), 7);
    chk(o_cq && cq_head_qid == 3 && cq_head_val == 7, "R4", "head load q3",
        {o_cq, cq_head_qid, cq_head_val}, {1'b1, 6'd3, 16'd7});
    chk(o_irq && irq_qid == 3, "R11", "irq after head", {o_irq, irq_qid}, {1'b1, 6'd3});
    // R11: head catches tail -> no irq
    wr(cq_db(4), 5);
    chk(o_cq && !o_irq, "R11", "no irq when empty", {o_cq, o_irq}, 2'b10);
    b_irq[5] = 0;
    wr(cq_db(5), 9);
    chk(o_cq && !o_irq, "R11", "no irq when disabled", {o_cq, o_irq}, 2'b10);
    b_irq[5] = 1;
    // R5: high data bits ignored
    wr(sq_db(1), 32'hABCD_0003);
    chk(o_sq && sq_tail_val == 3, "R5", "low half only", sq_tail_val, 3);
    // R6: out of range and not live
    wr(sq_db(9), 1);
    chk(!o_sq && !o_cq, "R6", "qid beyond NUM_Q", {o_sq, o_cq}, 0);
    wr(32'h8000, 1);
    chk(!o_sq && !o_cq, "R6", "far qid", {o_sq, o_cq}, 0);
    b_sq_live[6] = 0;
    wr(sq_db(6), 1);
    chk(!o_sq, "R6", "dead sq", o_sq, 0);
    b_sq_live[6] = 1;
    b_cq_live[6] = 0;
    wr(cq_db(6), 1);
    chk(!o_cq, "R6", "dead cq", o_cq, 0);
    b_cq_live[6] = 1;
    // R7: pointer bound
    wr(sq_db(0), 16);
    chk(!o_sq, "R7", "tail == depth", o_sq, 0);
    wr(cq_db(0), 20);
    chk(!o_cq, "R7", "head > depth", o_cq, 0);
    wr(sq_db(0), 15);
    chk(o_sq, "R7", "tail == depth-1", o_sq, 1);
    idle(D + 4);

    // R8: single fetch per tail write
    f1 = fcnt[3];
    wr(sq_db(3), 2);
    idle(D + 4);
    chk(fcnt[3] - f1 == 1, "R8", "one fetch pulse q3", fcnt[3] - f1, 1);

    // R9: re-arm exactly at the expiry cycle, and early re-arm
    f1 = fcnt[1];
    wr(sq_db(1), 4);
    idle(D - 2);
    wr(sq_db(1), 6);
    idle(2 * D);
    chk(fcnt[1] - f1 == 1, "R9", "re-arm at expiry", fcnt[1] - f1, 1);
    f1 = fcnt[1];
    wr(sq_db(1), 7);
    idle(10);
    wr(sq_db(1), 8);
    idle(D + 4);
    chk(fcnt[1] - f1 == 1, "R9", "early re-arm", fcnt[1] - f1, 1);

    // R10: freeing a full ring restarts bound queues (2 and 6 map to ring 2)
    b_cq_dep[2] = 8; b_tail[2] = 3; b_head[2] = 4;
    f2 = fcnt[2]; f6 = fcnt[6]; p2 = pcnt[2]; f1 = fcnt[1];
    wr(sq_db(2), 1);
    idle(20);
    wr(cq_db(2), 1);
    idle(D + 4);
    chk(fcnt[2] - f2 == 1, "R10", "restart sq2 (pending merged)", fcnt[2] - f2, 1);
    chk(fcnt[6] - f6 == 1, "R10", "restart sq6", fcnt[6] - f6, 1);
    chk(pcnt[2] - p2 == 1, "R10", "poster kick ring2", pcnt[2] - p2, 1);
    chk(fcnt[1] - f1 == 0, "R10", "unbound sq1 untouched", fcnt[1] - f1, 0);
    // not full: nothing armed
    f1 = fcnt[1]; f5 = fcnt[5]; p1 = pcnt[1];
    wr(cq_db(1), 2);
    idle(D + 4);
    chk(fcnt[1] - f1 == 0 && fcnt[5] - f5 == 0, "R10", "no restart when not full",
        fcnt[1] - f1 + fcnt[5] - f5, 0);
    chk(pcnt[1] - p1 == 0, "R10", "no poster kick when not full", pcnt[1] - p1, 0);

    // Random phase
    for (int n = 0; n < 400; n++) begin
      int a, d, q;
      if (n % 25 == 0) tables_random();
      q = $urandom % (NQ + 2);
      a = 32'h1000 + 8 * q + (($urandom % 2) ? 4 : 0);
      case ($urandom % 10)
        0: a = a - 32'h800;
        1: a = a + 1 + $urandom % 3;
        default: ;
      endcase
      d = ($urandom & 32'hFFFF_0000) | ($urandom % 18);
      wr(a, d);
      idle($urandom % 4);
    end
    idle(D + 6);

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(150000 * 10);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule